// File: doc/BRIEF.md
# Saturating Two-Channel Audio Mixer

This block combines two streams of offset-binary audio codes into a single offset-binary stream. The code 128 stands for silence. Each input code is first turned into a two's-complement sample by removing the mid-scale offset. The two samples are added in an adder one bit wider than the inputs, so the sum is exact. The sum is then limited to the full-scale range of the output width, and the mid-scale offset of the output is restored. When a sample has to be limited, a clip strobe marks it.

Each input port and the output port use a valid/ready handshake. A pair of input codes is taken only when both inputs are valid in the same cycle and the output slot can take a new result. The two codes are consumed together. The block keeps up with one sample per cycle, and each result appears in the cycle after its inputs are taken. The output width is a parameter. Its positive full scale is 2^(OUT_W-1)-1 and its negative full scale is -2^(OUT_W-1). With the default widths of 8 and 8, the output codes run from 0 to 255.

Top module: `audio_mix_sat`

## Requirements
- R1: An input code c stands for the signed sample c - 2^(IN_W-1). For the default width, code 128 is 0, code 255 is +127 and code 0 is -128.
- R2: The two signed samples are added exactly in IN_W+1 bits. For example, codes 200 and 100 give 72 + (-28) = 44, which is output code 172 with no clip.
- R3: A sum above 2^(OUT_W-1)-1 is replaced by that value. This is output code all-ones, 255 by default.
- R4: A sum below -2^(OUT_W-1) is replaced by that value. This is output code 0.
- R5: The sum never wraps. Samples +125 and +125 (codes 253 and 253) give code 255, never the wrapped value.
- R6: Samples of equal size and opposite sign cancel. Codes 32 and 224 (-96 and +96) give code 128.
- R7: The output code is the limited signed sum plus 2^(OUT_W-1).
- R8: A pair is taken only when a_valid and b_valid are both high and the output slot is free. a_ready is high only when b_valid is high, and b_ready only when a_valid is high. A lone valid input is not consumed and produces no output.
- R9: The result of a pair taken at a clock edge is presented on out_valid/out_data right after that edge. With out_ready held high, a new pair can be taken on every cycle.
- R10: While out_valid is high and out_ready is low, out_data holds its value and no new pair is taken.
- R11: out_clip is high for exactly one cycle, the cycle right after a pair whose sum had to be limited is taken. It is low at every other time.
- R12: While rst_n is low, out_valid and out_clip are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| a_valid | input | 1 | Channel A code valid |
| a_ready | output | 1 | Channel A code taken |
| a_data | input | IN_W | Channel A offset-binary code |
| b_valid | input | 1 | Channel B code valid |
| b_ready | output | 1 | Channel B code taken |
| b_data | input | IN_W | Channel B offset-binary code |
| out_valid | output | 1 | Mixed sample valid |
| out_ready | input | 1 | Downstream accepts sample |
| out_data | output | OUT_W | Mixed offset-binary code |
| out_clip | output | 1 | One-cycle strobe for a limited sample |

## Verification
Limiting and back-pressure can both act on the same sample. A clipped result can arrive while out_ready is low, so the held code must stay at full scale and the clip strobe must still fall after one cycle. The bench makes this happen by stalling out_ready right after directed overflow pairs, and also over a long random run. A behavioural model predicts the acceptance, the held code and the strobe timing, and the design is compared against it on every cycle.

// File: rtl/mix_pkg.sv
package mix_pkg;
  typedef enum logic [1:0] {
    CL_NONE = 2'd0,
    CL_HIGH = 2'd1,
    CL_LOW  = 2'd2
  } clamp_e;

  function automatic int wider(input int x, input int y);
    return (x > y) ? x : y;
  endfunction
endpackage

// File: rtl/code_to_signed.sv
module code_to_signed #(
  parameter int W = 8
) (
  input  logic [W-1:0]        code,
  output logic signed [W-1:0] val
);
  function automatic logic signed [W-1:0] unbias(input logic [W-1:0] c);
    return $signed({~c[W-1], c[W-2:0]});
  endfunction

  assign val = unbias(code);
endmodule

// File: rtl/sat_clamp.sv
module sat_clamp
  import mix_pkg::*;
#(
  parameter int SUM_W = 9,
  parameter int OUT_W = 8
) (
  input  logic signed [SUM_W-1:0] sum,
  output logic [OUT_W-1:0]        code,
  output clamp_e                  kind
);
  localparam int CMP_W = wider(SUM_W, OUT_W) + 1;
  localparam logic signed [CMP_W-1:0] POS_FS = CMP_W'((64'sd1 <<< (OUT_W-1)) - 64'sd1);
  localparam logic signed [CMP_W-1:0] NEG_FS = -POS_FS - CMP_W'(1);

  logic signed [CMP_W-1:0] ext;
  logic signed [OUT_W-1:0] lim;

  function automatic logic [OUT_W-1:0] rebias(input logic signed [OUT_W-1:0] s);
    return {~s[OUT_W-1], s[OUT_W-2:0]};
  endfunction

  assign ext = {{(CMP_W-SUM_W){sum[SUM_W-1]}}, sum};

  always_comb begin
    if (ext > POS_FS) begin
      kind = CL_HIGH;
      lim  = POS_FS[OUT_W-1:0];
    end else if (ext < NEG_FS) begin
      kind = CL_LOW;
      lim  = NEG_FS[OUT_W-1:0];
    end else begin
      kind = CL_NONE;
      lim  = ext[OUT_W-1:0];
    end
  end

  assign code = rebias(lim);
endmodule

// File: rtl/mix_out_stage.sv
module mix_out_stage
  import mix_pkg::*;
#(
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OUT_W-1:0] code_in,
  input  clamp_e           kind_in,
  input  logic             ready,
  output logic             slot_free,
  output logic             valid,
  output logic [OUT_W-1:0] code,
  output logic             clip
);
  assign slot_free = !valid || ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      code  <= '0;
      clip  <= 1'b0;
    end else begin
      clip <= load && (kind_in != CL_NONE);
      if (load) begin
        valid <= 1'b1;
        code  <= code_in;
      end else if (ready) begin
        valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/audio_mix_sat.sv
module audio_mix_sat
  import mix_pkg::*;
#(
  parameter int IN_W  = 8,
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_valid,
  output logic             a_ready,
  input  logic [IN_W-1:0]  a_data,
  input  logic             b_valid,
  output logic             b_ready,
  input  logic [IN_W-1:0]  b_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OUT_W-1:0] out_data,
  output logic             out_clip
);
  localparam int SUM_W = IN_W + 1;
  localparam int NCH   = 2;

  logic [IN_W-1:0]        ch_code [NCH];
  logic signed [IN_W-1:0] ch_val  [NCH];
  logic signed [SUM_W-1:0] mix_sum;
  logic [OUT_W-1:0]       lim_code;
  clamp_e                 clip_kind;
  logic                   slot_free;
  logic                   accept;

  assign ch_code[0] = a_data;
  assign ch_code[1] = b_data;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    code_to_signed #(.W(IN_W)) u_unbias (
      .code (ch_code[i]),
      .val  (ch_val[i])
    );
  end

  function automatic logic signed [SUM_W-1:0] exact_add(
    input logic signed [IN_W-1:0] x,
    input logic signed [IN_W-1:0] y
  );
    return SUM_W'(x) + SUM_W'(y);
  endfunction

  assign mix_sum = exact_add(ch_val[0], ch_val[1]);

  sat_clamp #(.SUM_W(SUM_W), .OUT_W(OUT_W)) u_clamp (
    .sum  (mix_sum),
    .code (lim_code),
    .kind (clip_kind)
  );

  assign accept  = a_valid && b_valid && slot_free;
  assign a_ready = b_valid && slot_free;
  assign b_ready = a_valid && slot_free;

  mix_out_stage #(.OUT_W(OUT_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .code_in   (lim_code),
    .kind_in   (clip_kind),
    .ready     (out_ready),
    .slot_free (slot_free),
    .valid     (out_valid),
    .code      (out_data),
    .clip      (out_clip)
  );
endmodule

// File: rtl/mix_checker.sv
module mix_checker #(
  parameter int OUT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             a_valid,
  input logic             a_ready,
  input logic             b_valid,
  input logic             b_ready,
  input logic             accept,
  input logic             out_valid,
  input logic             out_ready,
  input logic [OUT_W-1:0] out_data,
  input logic             out_clip
);
  assert_joint_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (a_valid && a_ready) == (b_valid && b_ready));

  assert_next_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> out_valid);

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_clip_fullscale_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_clip |-> (out_valid && (out_data == '0 || out_data == '1)));

  assert_clip_from_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
    out_clip |-> $past(accept));
endmodule

bind audio_mix_sat mix_checker #(.OUT_W(OUT_W)) u_mix_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .a_valid   (a_valid),
  .a_ready   (a_ready),
  .b_valid   (b_valid),
  .b_ready   (b_ready),
  .accept    (accept),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_clip  (out_clip)
);

// File: tb/tb_audio_mix_sat.sv
module tb_audio_mix_sat;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       a_valid = 1'b0, b_valid = 1'b0, out_ready = 1'b0;
  logic [7:0] a_data = 8'd0, b_data = 8'd0;
  logic       a_ready, b_ready, out_valid, out_clip;
  logic [7:0] out_data;

  int n_cmp = 0;
  int n_bad = 0;

  bit       m_valid = 1'b0;
  bit       m_clip  = 1'b0;
  int       m_code  = 0;

  always #(CLK_P/2) clk = ~clk;

  audio_mix_sat dut (
    .clk(clk), .rst_n(rst_n),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_clip(out_clip)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int mix_ref(input int ca, input int cb, output bit clipped);
    int s;
    s = (ca - 128) + (cb - 128);
    clipped = 1'b0;
    if (s > 127) begin s = 127; clipped = 1'b1; end
    if (s < -128) begin s = -128; clipped = 1'b1; end
    return s + 128;
  endfunction

  task automatic step(input bit av, input int ad, input bit bv, input int bd,
                      input bit ordy, input string req);
    bit free, take, cl;
    int code;
    a_valid = av; a_data = 8'(ad);
    b_valid = bv; b_data = 8'(bd);
    out_ready = ordy;
    #1;
    free = !m_valid || ordy;
    take = av && bv && free;
    chk(a_ready == (bv && free), "R8 a_ready", int'(a_ready), int'(bv && free));
    chk(b_ready == (av && free), "R8 b_ready", int'(b_ready), int'(av && free));
    code = mix_ref(ad, bd, cl);
    @(posedge clk);
    if (take) begin
      m_valid = 1'b1; m_code = code; m_clip = cl;
    end else begin
      if (ordy) m_valid = 1'b0;
      m_clip = 1'b0;
    end
    @(negedge clk);
    chk(out_valid == m_valid, {req, " R9 valid"}, int'(out_valid), int'(m_valid));
    if (m_valid)
      chk(int'(out_data) == m_code, {req, " data"}, int'(out_data), m_code);
    chk(out_clip == m_clip, {req, " R11 clip"}, int'(out_clip), int'(m_clip));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=expired expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R12 valid in reset", int'(out_valid), 0);
    chk(out_clip == 1'b0, "R12 clip in reset", int'(out_clip), 0);
    rst_n = 1'b1;
    @(negedge clk);

    step(1, 253, 1, 253, 1, "R5 R3 no wrap");
    step(1, 255, 1, 255, 1, "R3 positive full scale");
    step(1, 3,   1, 3,   1, "R4 negative full scale");
    step(1, 0,   1, 0,   1, "R4 most negative");
    step(1, 32,  1, 224, 1, "R6 cancel");
    step(1, 128, 1, 128, 1, "R1 silence");
    step(1, 200, 1, 100, 1, "R2 R7 exact sum");
    step(1, 255, 1, 128, 1, "R1 R7 edge no clip");
    step(1, 0,   1, 127, 1, "R4 R2 edge below");
    step(1, 90,  0, 10,  1, "R8 lone a");
    step(0, 90,  1, 10,  1, "R8 lone b");
    step(0, 0,   0, 0,   1, "R9 idle");
    step(1, 250, 1, 240, 0, "R10 R11 clip then stall");
    step(1, 10,  1, 20,  0, "R10 hold");
    step(1, 10,  1, 20,  0, "R10 hold again");
    step(1, 10,  1, 20,  1, "R10 release");
    step(1, 60,  1, 70,  1, "R9 back to back");
    step(1, 61,  1, 71,  1, "R9 back to back");

    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 8) != 0, int'($urandom % 256),
           ($urandom % 8) != 0, int'($urandom % 256),
           ($urandom % 4) != 0, "random R7");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule